// File: doc/BRIEF.md
# Slice-Addressed Register File

This block is a small register file for a datapath that handles a 32-bit word one byte lane at a time. It holds sixteen words. Every access, read or write, touches only one 8-bit lane of a word. A single lane selector is shared by all ports, so both read ports and the write port always work on the same lane in a given cycle.

There are two read ports. Each returns its lane combinationally in the cycle its address is presented. There is one write port, which commits on the rising clock edge. Entry zero is a constant: it always reads as zero and discards every write.

A synchronous active-low reset clears the whole array. The complete array is also driven onto a flat debug output so that a bench or neighbouring logic can observe the storage directly.

Top module: `slice_reg_file`

## Requirements
- R1: The array holds 16 words of 32 bits. The debug output carries word n on bits [n*32+31 : n*32].
- R2: The lane selector value k picks bits [k*8+7 : k*8] of a word. The same k applies to both read ports and to the write port.
- R3: Each read port returns lane k of the word at its read address in the same cycle, with no clock edge between address and data.
- R4: A read port whose address is 0 returns 0 at all times, including before any reset has been applied.
- R5: On a rising edge where write enable is 1, reset is high and the write address is nonzero, the 8-bit write data is stored into lane k of the addressed word.
- R6: Such a write leaves the other three lanes of the target word, and every other word, unchanged.
- R7: On a rising edge where write enable is 0 and reset is high, no stored bit changes.
- R8: A write to address 0 is discarded, whatever the write enable. Word 0 on the debug output stays 0.
- R9: When reset is low at a rising edge, every word reads 0 after that edge.
- R10: A write presented in the same cycle as a low reset is dropped, and the array is cleared.
- R11: A read of the address being written in the same cycle returns the value held before that edge. There is no bypass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| sliceSel | input | 2 | Lane selector shared by all ports |
| rdAddr | input | 2x4 | Read addresses, one per read port (port p at index p) |
| rdData | output | 2x8 | Read lanes, one per read port |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write lane data |
| dbgArray | output | 512 | Whole array, word n at bits [n*32+31 : n*32] |

## Verification
Read data is due in the same cycle as its address. The bench drives all inputs just after a falling edge and compares both read lanes one time unit later, before the next rising edge. At that point the reads still show the pre-edge contents, which is also how the no-bypass rule is checked. Writes and the reset clear become visible one edge later. After each rising edge the bench compares the debug output against its own model, updated for that edge. Random traffic is mixed with directed cases for entry zero, lane isolation, reset during a write, and the read before the first reset.

// File: rtl/slice_rf_pkg.sv
package slice_rf_pkg;

  // Strobes passed from the write control to the storage datapath.
  typedef struct packed {
    logic clearAll;  // synchronous clear of every stored word
    logic commit;    // a lane write lands on this edge
  } rfStrobe_t;

endpackage : slice_rf_pkg

// File: rtl/slice_rf_control.sv
module slice_rf_control
  import slice_rf_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int SLICES    = 4,
  localparam int ADDR_W   = $clog2(NUM_WORDS),
  localparam int SEL_W    = $clog2(SLICES)
) (
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [SEL_W-1:0]     sliceSel,
  output rfStrobe_t            strobe,
  output logic [NUM_WORDS-1:0] wordHit,
  output logic [SLICES-1:0]    laneHit
);

  logic addrIsZero;
  assign addrIsZero = (wrAddr == '0);

  // Reset wins over any write presented in the same cycle.
  always_comb begin
    strobe.clearAll = !rstN;
    strobe.commit   = rstN && wrEn && !addrIsZero;
  end

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_wordDec
      assign wordHit[w] = (wrAddr == ADDR_W'(w));
    end
  endgenerate

  genvar l;
  generate
    for (l = 0; l < SLICES; l++) begin : g_laneDec
      assign laneHit[l] = (sliceSel == SEL_W'(l));
    end
  endgenerate

endmodule : slice_rf_control

// File: rtl/slice_rf_datapath.sv
module slice_rf_datapath
  import slice_rf_pkg::*;
#(
  parameter int NUM_WORDS  = 16,
  parameter int WORD_W     = 32,
  parameter int SLICE_W    = 8,
  parameter int READ_PORTS = 2,
  localparam int ADDR_W    = $clog2(NUM_WORDS),
  localparam int SLICES    = WORD_W / SLICE_W,
  localparam int SEL_W     = $clog2(SLICES)
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  rfStrobe_t                             strobe,
  input  logic [NUM_WORDS-1:0]                  wordHit,
  input  logic [SLICES-1:0]                     laneHit,
  input  logic [SLICE_W-1:0]                    wrData,
  input  logic [SEL_W-1:0]                      sliceSel,
  input  logic [READ_PORTS-1:0][ADDR_W-1:0]     rdAddr,
  output logic [READ_PORTS-1:0][SLICE_W-1:0]    rdData,
  output logic [NUM_WORDS*WORD_W-1:0]           dbgArray
);

  // Each word is viewed as a packed vector of lanes; lane 0 sits at the LSBs.
  logic [SLICES-1:0][SLICE_W-1:0] wordQ [NUM_WORDS];

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      if (w == 0) begin : g_hardZero
        assign wordQ[w] = '0;
      end else begin : g_store
        logic [SLICES-1:0][SLICE_W-1:0] store;
        always_ff @(posedge clk) begin
          if (strobe.clearAll) begin
            store <= '0;
          end else if (strobe.commit && wordHit[w]) begin
            for (int l = 0; l < SLICES; l++) begin
              if (laneHit[l]) store[l] <= wrData;
            end
          end
        end
        assign wordQ[w] = store;
      end
    end
  endgenerate

  // Combinational read lanes; entry zero is a constant so no special case.
  genvar p;
  generate
    for (p = 0; p < READ_PORTS; p++) begin : g_rd
      logic [SLICES-1:0][SLICE_W-1:0] sel;
      assign sel       = wordQ[rdAddr[p]];
      assign rdData[p] = sel[sliceSel];

      p_zero_read_r4 : assert property (@(posedge clk) disable iff (!rstN)
        (rdAddr[p] == '0) |-> (rdData[p] == '0))
        else $error("R4 read of entry zero not zero");
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NUM_WORDS; i++) begin
      dbgArray[i*WORD_W +: WORD_W] = wordQ[i];
    end
  end

endmodule : slice_rf_datapath

// File: rtl/slice_reg_file.sv
module slice_reg_file
  import slice_rf_pkg::*;
#(
  parameter int NUM_WORDS  = 16,
  parameter int WORD_W     = 32,
  parameter int SLICE_W    = 8,
  parameter int READ_PORTS = 2,
  localparam int ADDR_W    = $clog2(NUM_WORDS),
  localparam int SLICES    = WORD_W / SLICE_W,
  localparam int SEL_W     = $clog2(SLICES)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [SEL_W-1:0]                   sliceSel,
  input  logic [READ_PORTS-1:0][ADDR_W-1:0]  rdAddr,
  output logic [READ_PORTS-1:0][SLICE_W-1:0] rdData,
  input  logic                               wrEn,
  input  logic [ADDR_W-1:0]                  wrAddr,
  input  logic [SLICE_W-1:0]                 wrData,
  output logic [NUM_WORDS*WORD_W-1:0]        dbgArray
);

  rfStrobe_t              strobe;
  logic [NUM_WORDS-1:0]   wordHit;
  logic [SLICES-1:0]      laneHit;

  slice_rf_control #(
    .NUM_WORDS(NUM_WORDS),
    .SLICES   (SLICES)
  ) u_control (
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .sliceSel(sliceSel),
    .strobe  (strobe),
    .wordHit (wordHit),
    .laneHit (laneHit)
  );

  slice_rf_datapath #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .SLICE_W   (SLICE_W),
    .READ_PORTS(READ_PORTS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wordHit (wordHit),
    .laneHit (laneHit),
    .wrData  (wrData),
    .sliceSel(sliceSel),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .dbgArray(dbgArray)
  );

  // Lane view of the debug port for the port-level properties below.
  logic [NUM_WORDS-1:0][SLICES-1:0][SLICE_W-1:0] dbgLanes;
  assign dbgLanes = dbgArray;

  p_clear_r9 : assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (dbgArray == '0))
    else $error("R9 array not cleared after reset");

  p_hold_r7 : assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(dbgArray))
    else $error("R7 storage changed without write enable");

  p_lane_write_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != '0) |=> (dbgLanes[$past(wrAddr)][$past(sliceSel)] == $past(wrData)))
    else $error("R5 written lane does not hold write data");

  p_entry0_r8 : assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (dbgLanes[0] == '0))
    else $error("R8 entry zero became nonzero");

endmodule : slice_reg_file

// File: tb/tb_slice_reg_file.sv
module tb_slice_reg_file;

  logic             clk = 1'b0;
  logic             rstN;
  logic [1:0]       sliceSel;
  logic [1:0][3:0]  rdAddr;
  logic [1:0][7:0]  rdData;
  logic             wrEn;
  logic [3:0]       wrAddr;
  logic [7:0]       wrData;
  logic [511:0]     dbgArray;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [31:0] model [16];

  always #5 clk = ~clk;

  slice_reg_file dut (
    .clk(clk), .rstN(rstN), .sliceSel(sliceSel), .rdAddr(rdAddr),
    .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgArray(dbgArray)
  );

  function automatic logic [7:0] expRead(input logic [3:0] a, input logic [1:0] k);
    logic [31:0] wd;
    wd = (a == 4'd0) ? 32'd0 : model[a];
    return wd[k*8 +: 8];
  endfunction

  function automatic logic [511:0] packModel();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = model[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // One cycle: drive after falling edge, check reads before the rising edge,
  // then check the array one edge later against the model.
  task automatic step(input logic rst, input logic en, input logic [3:0] wa,
                      input logic [7:0] wd, input logic [1:0] k,
                      input logic [3:0] ra0, input logic [3:0] ra1, input string tag);
    @(negedge clk);
    rstN = rst; wrEn = en; wrAddr = wa; wrData = wd; sliceSel = k;
    rdAddr[0] = ra0; rdAddr[1] = ra1;
    #1;
    chk({tag, " R3 port0"}, 512'(rdData[0]), 512'(expRead(ra0, k)));
    chk({tag, " R3 port1"}, 512'(rdData[1]), 512'(expRead(ra1, k)));
    @(posedge clk);
    if (!rst) begin
      for (int i = 0; i < 16; i++) model[i] = 32'd0;
    end else if (en && wa != 4'd0) begin
      model[wa][k*8 +: 8] = wd;
    end
    #1;
    chk({tag, " R6 array"}, dbgArray, packModel());
  endtask

  initial begin
    #150000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = 32'd0;
    // R4: entry zero reads zero before any reset has been applied.
    rstN = 1'b1; wrEn = 1'b0; wrAddr = '0; wrData = '0; sliceSel = 2'd2;
    rdAddr[0] = 4'd0; rdAddr[1] = 4'd0;
    #1;
    chk("R4 pre-reset port0", 512'(rdData[0]), 512'd0);
    chk("R4 pre-reset port1", 512'(rdData[1]), 512'd0);
    rstN = 1'b0;
    #2;

    // R9: reset clears the array.
    step(1'b0, 1'b0, 4'd0, 8'h00, 2'd0, 4'd1, 4'd2, "R9 reset");
    step(1'b0, 1'b0, 4'd0, 8'h00, 2'd0, 4'd1, 4'd2, "R9 reset");
    chk("R9 reset state", dbgArray, 512'd0);

    // R2/R5/R6: fill all four lanes of word 5, then check lane isolation.
    step(1'b1, 1'b1, 4'd5, 8'hA0, 2'd0, 4'd5, 4'd0, "R5 lane0");
    step(1'b1, 1'b1, 4'd5, 8'hB1, 2'd1, 4'd5, 4'd0, "R5 lane1");
    step(1'b1, 1'b1, 4'd5, 8'hC2, 2'd2, 4'd5, 4'd0, "R5 lane2");
    step(1'b1, 1'b1, 4'd5, 8'hD3, 2'd3, 4'd5, 4'd0, "R5 lane3");
    chk("R2 word5 lane order", 512'(dbgArray[5*32 +: 32]), 512'(32'hD3C2B1A0));
    step(1'b1, 1'b1, 4'd5, 8'h11, 2'd2, 4'd5, 4'd5, "R6 one lane");
    chk("R6 other lanes kept", 512'(dbgArray[5*32 +: 32]), 512'(32'hD311B1A0));
    chk("R1 word5 placement", dbgArray, 512'(32'hD311B1A0) << (5*32));

    // R11: same-cycle read of the written address sees the old lane.
    step(1'b1, 1'b1, 4'd5, 8'h77, 2'd2, 4'd5, 4'd5, "R11 no bypass");
    step(1'b1, 1'b0, 4'd0, 8'h00, 2'd2, 4'd5, 4'd0, "R11 follow");
    chk("R11 new lane visible next cycle", 512'(rdData[0]), 512'(8'h77));

    // R7: disabled write does nothing.
    step(1'b1, 1'b0, 4'd5, 8'hEE, 2'd0, 4'd5, 4'd5, "R7 disabled");
    chk("R7 lane0 unchanged", 512'(dbgArray[5*32 +: 8]), 512'(8'hA0));

    // R8: writes to entry zero are discarded.
    step(1'b1, 1'b1, 4'd0, 8'hFF, 2'd1, 4'd0, 4'd0, "R8 write0");
    chk("R8 word0 zero", 512'(dbgArray[31:0]), 512'd0);
    step(1'b1, 1'b1, 4'd0, 8'h5A, 2'd1, 4'd0, 4'd0, "R4 read0 after write0");

    // R10: reset beats a concurrent write.
    step(1'b0, 1'b1, 4'd9, 8'h3C, 2'd3, 4'd9, 4'd5, "R10 reset+write");
    chk("R10 array cleared", dbgArray, 512'd0);

    // Random traffic.
    for (int n = 0; n < 3000; n++) begin
      logic r;
      r = ($urandom % 64) != 0;
      step(r, ($urandom % 4) != 0, 4'($urandom), 8'($urandom), 2'($urandom),
           4'($urandom), 4'($urandom), "random");
    end

    finish_run();
  end

endmodule : tb_slice_reg_file